// File: doc/BRIEF.md
# H-Bridge PWM Driver with Back-EMF Sampling Gap

This block drives one DC motor through a two-half H-bridge. Each half has an enable line and a level line. The block applies a coarse duty cycle: every PWM period is split into eight equal steps, and a power level sets how many of the leading steps drive the motor. In the remaining steps both halves are released to high impedance, so the motor coasts rather than recirculating. A direction input chooses which half pulls high. A brake input enables both halves with both levels low, which shorts the motor windings.

After a fixed number of PWM periods, the block inserts a longer gap in which both halves stay released. Partway into that gap, once the winding voltage has had time to settle, it pulses a one-cycle measurement request. An external converter uses that pulse to sample the motor's back-EMF, which can serve as a speed estimate. The step length, the number of periods between gaps, the gap length and the settle delay are all parameters given in clock cycles.

Top module: `hb_pwm_bemf`

## Requirements
- R1: A period is 8 steps of STEP_CYCLES cycles each. With a captured level L, the halves are enabled during steps 0 to L-1 of that period. The first period after reset is treated as level 0.
- R2: During a driven step with captured direction 0, half A is driven high and half B low (lvl_a_o=1, lvl_b_o=0). With direction 1 the levels are swapped. Both enables are 1 in either case.
- R3: During an undriven step without brake, both enables and both level lines are 0. This includes every step when the level is 0.
- R4: A captured level of 8 or more (level_i is 4 bits) drives all 8 steps of the period.
- R5: While brake_i is 1, both enables are 1 and both level lines are 0 in the same cycle. This overrides every other state.
- R6: level_i and dir_i are captured only on the clock edge that starts a period, so changes made mid-period have no effect until the next period starts.
- R7: After every PERIODS_PER_WIN periods, a gap of WIN_CYCLES cycles follows with both enables and both level lines at 0. The next period starts right after the gap.
- R8: meas_o is high for exactly one cycle per gap. That cycle is the one SETTLE_CYCLES cycles after the gap's first cycle (SETTLE_CYCLES < WIN_CYCLES). meas_o is 0 at all other times.
- R9: Brake suppresses meas_o, including inside a gap. The period and gap timing keeps running while brake is applied.
- R10: While rst_ni is low, all five outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| level_i | input | 4 | Power level, 0..8; values above 8 act as 8 |
| dir_i | input | 1 | Direction: 0 drives half A high, 1 drives half B high |
| brake_i | input | 1 | Brake command: both halves enabled and driven low |
| en_a_o | output | 1 | Enable for bridge half A |
| en_b_o | output | 1 | Enable for bridge half B |
| lvl_a_o | output | 1 | Level for bridge half A |
| lvl_b_o | output | 1 | Level for bridge half B |
| meas_o | output | 1 | One-cycle back-EMF sample request |

## Verification
The assertions check the following on every cycle:
- Brake output state.
- The two enables always match.
- The two level lines are never both high.
- A released half never carries a high level.
- The sample request is one cycle wide, never occurs under brake, and only occurs while both halves are released.

Some behaviour only the bench scenarios can show, by comparing against a cycle-counting model of periods and gaps:
- Where the on steps fall within a period.
- That level and direction are captured only at period starts.
- The gap spacing and length.
- The exact cycle of the sample request.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;
  localparam int STEPS      = 8;
  localparam int STEP_IDX_W = 3;
  localparam int LEVEL_W    = 4;

  typedef enum logic {PH_RUN, PH_GAP} phase_e;

  typedef struct packed {
    logic [LEVEL_W-1:0] level;
    logic               dir;
  } cmd_t;
endpackage

// File: rtl/hb_timebase.sv
module hb_timebase
  import hb_pwm_pkg::*;
#(
  parameter int STEP_CYCLES     = 8,
  parameter int PERIODS_PER_WIN = 4,
  parameter int WIN_CYCLES      = 24,
  localparam int CycW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1,
  localparam int PerW = (PERIODS_PER_WIN > 1) ? $clog2(PERIODS_PER_WIN) : 1,
  localparam int WinW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [STEP_IDX_W-1:0] step_o,
  output logic                  in_win_o,
  output logic [WinW-1:0]       win_cnt_o,
  output logic                  load_o
);
  phase_e                phase_q;
  logic [CycW-1:0]       cyc_q;
  logic [STEP_IDX_W-1:0] step_q;
  logic [PerW-1:0]       per_q;
  logic [WinW-1:0]       wcnt_q;
  logic                  cyc_last, step_last, per_last, wcnt_last;

  assign cyc_last  = (cyc_q == CycW'(STEP_CYCLES - 1));
  assign step_last = (step_q == STEP_IDX_W'(STEPS - 1));
  assign per_last  = (per_q == PerW'(PERIODS_PER_WIN - 1));
  assign wcnt_last = (wcnt_q == WinW'(WIN_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RUN;
      cyc_q   <= '0;
      step_q  <= '0;
      per_q   <= '0;
      wcnt_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_RUN: begin
          if (cyc_last) begin
            cyc_q <= '0;
            if (step_last) begin
              step_q <= '0;
              if (per_last) begin
                per_q   <= '0;
                phase_q <= PH_GAP;
              end else begin
                per_q <= per_q + 1'b1;
              end
            end else begin
              step_q <= step_q + 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        PH_GAP: begin
          if (wcnt_last) begin
            wcnt_q  <= '0;
            phase_q <= PH_RUN;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  // edge after this cycle opens a new period
  assign load_o = (phase_q == PH_RUN && cyc_last && step_last && !per_last) ||
                  (phase_q == PH_GAP && wcnt_last);
  assign step_o    = step_q;
  assign in_win_o  = (phase_q == PH_GAP);
  assign win_cnt_o = wcnt_q;
endmodule

// File: rtl/hb_cmd_latch.sv
module hb_cmd_latch
  import hb_pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cmd_t cmd_i,
  output cmd_t cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_o <= '0;
    else if (load_i) cmd_o <= cmd_i;
  end
endmodule

// File: rtl/hb_out_drive.sv
module hb_out_drive
  import hb_pwm_pkg::*;
#(
  parameter int WIN_CYCLES    = 24,
  parameter int SETTLE_CYCLES = 10,
  localparam int WinW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1
) (
  input  logic                  rst_ni,
  input  logic                  brake_i,
  input  logic                  in_win_i,
  input  logic [STEP_IDX_W-1:0] step_i,
  input  logic [WinW-1:0]       win_cnt_i,
  input  cmd_t                  cmd_i,
  output logic                  en_a_o,
  output logic                  en_b_o,
  output logic                  lvl_a_o,
  output logic                  lvl_b_o,
  output logic                  meas_o
);
  logic on;

  assign on = !in_win_i && ({1'b0, step_i} < cmd_i.level);

  always_comb begin
    en_a_o  = 1'b0;
    en_b_o  = 1'b0;
    lvl_a_o = 1'b0;
    lvl_b_o = 1'b0;
    meas_o  = 1'b0;
    if (rst_ni) begin
      if (brake_i) begin
        en_a_o = 1'b1;
        en_b_o = 1'b1;
      end else begin
        en_a_o  = on;
        en_b_o  = on;
        lvl_a_o = on & ~cmd_i.dir;
        lvl_b_o = on & cmd_i.dir;
        meas_o  = in_win_i && (win_cnt_i == WinW'(SETTLE_CYCLES));
      end
    end
  end
endmodule

// File: rtl/hb_pwm_bemf.sv
module hb_pwm_bemf
  import hb_pwm_pkg::*;
#(
  parameter int STEP_CYCLES     = 8,
  parameter int PERIODS_PER_WIN = 4,
  parameter int WIN_CYCLES      = 24,
  parameter int SETTLE_CYCLES   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic               dir_i,
  input  logic               brake_i,
  output logic               en_a_o,
  output logic               en_b_o,
  output logic               lvl_a_o,
  output logic               lvl_b_o,
  output logic               meas_o
);
  localparam int WinW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

  logic [STEP_IDX_W-1:0] step;
  logic                  in_win;
  logic [WinW-1:0]       win_cnt;
  logic                  load;
  cmd_t                  cmd_in, cmd_q;

  assign cmd_in = '{level: level_i, dir: dir_i};

  hb_timebase #(
    .STEP_CYCLES    (STEP_CYCLES),
    .PERIODS_PER_WIN(PERIODS_PER_WIN),
    .WIN_CYCLES     (WIN_CYCLES)
  ) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_o   (step),
    .in_win_o (in_win),
    .win_cnt_o(win_cnt),
    .load_o   (load)
  );

  hb_cmd_latch u_cmd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cmd_i (cmd_in),
    .cmd_o (cmd_q)
  );

  hb_out_drive #(
    .WIN_CYCLES   (WIN_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_drv (
    .rst_ni   (rst_ni),
    .brake_i  (brake_i),
    .in_win_i (in_win),
    .step_i   (step),
    .win_cnt_i(win_cnt),
    .cmd_i    (cmd_q),
    .en_a_o   (en_a_o),
    .en_b_o   (en_b_o),
    .lvl_a_o  (lvl_a_o),
    .lvl_b_o  (lvl_b_o),
    .meas_o   (meas_o)
  );
endmodule

// File: rtl/hb_pwm_bemf_chk.sv
module hb_pwm_bemf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic brake_i,
  input logic en_a_o,
  input logic en_b_o,
  input logic lvl_a_o,
  input logic lvl_b_o,
  input logic meas_o
);
  AST_BRAKE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brake_i |-> (en_a_o && en_b_o && !lvl_a_o && !lvl_b_o)); // R5

  AST_NO_BOTH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lvl_a_o && lvl_b_o)); // R2

  AST_EN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_a_o == en_b_o); // R3

  AST_RELEASED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_a_o |-> (!lvl_a_o && !lvl_b_o)); // R3

  AST_MEAS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_o |=> !meas_o); // R8

  AST_MEAS_NO_BRAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brake_i |-> !meas_o); // R9

  AST_MEAS_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_o |-> (!en_a_o && !en_b_o)); // R7
endmodule

bind hb_pwm_bemf hb_pwm_bemf_chk u_chk (.*);

// File: tb/hb_pwm_bemf_test.sv
`timescale 1ns/1ps
module hb_pwm_bemf_test;
  localparam int STEP_CYCLES     = 8;
  localparam int PERIODS_PER_WIN = 4;
  localparam int WIN_CYCLES      = 24;
  localparam int SETTLE_CYCLES   = 10;
  localparam int SEG             = 1500;
  localparam int NSEG            = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] level_i;
  logic       dir_i;
  logic       brake_i;
  logic       en_a_o, en_b_o, lvl_a_o, lvl_b_o, meas_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  bit m_gap;
  int m_cyc, m_step, m_per, m_wcnt, m_lev;
  bit m_dir;

  always #2.5 clk_i = ~clk_i;

  hb_pwm_bemf #(
    .STEP_CYCLES    (STEP_CYCLES),
    .PERIODS_PER_WIN(PERIODS_PER_WIN),
    .WIN_CYCLES     (WIN_CYCLES),
    .SETTLE_CYCLES  (SETTLE_CYCLES)
  ) uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level_i),
    .dir_i  (dir_i),
    .brake_i(brake_i),
    .en_a_o (en_a_o),
    .en_b_o (en_b_o),
    .lvl_a_o(lvl_a_o),
    .lvl_b_o(lvl_b_o),
    .meas_o (meas_o)
  );

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {en_a_o, en_b_o, lvl_a_o, lvl_b_o, meas_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t {en_a,en_b,lvl_a,lvl_b,meas} actual=%b expected=%b",
               req, $time, act, exp);
    end
  endtask

  function automatic logic [4:0] expected();
    bit on;
    if (brake_i) return 5'b11000;
    if (m_gap) return {4'b0000, (m_wcnt == SETTLE_CYCLES)};
    on = (m_step < m_lev);
    return {on, on, on & ~m_dir, on & m_dir, 1'b0};
  endfunction

  function automatic string tag();
    if (brake_i && m_gap) return "R9";
    if (brake_i) return "R5";
    if (m_gap) return (m_wcnt == SETTLE_CYCLES) ? "R8" : "R7";
    if (int'(level_i) != m_lev || dir_i != m_dir) return "R6";
    if (m_lev >= 8) return "R4";
    if (m_step < m_lev) return "R1/R2";
    return "R3";
  endfunction

  task automatic model_reset();
    m_gap = 0; m_cyc = 0; m_step = 0; m_per = 0; m_wcnt = 0; m_lev = 0; m_dir = 0;
  endtask

  // advance model across the coming edge, using the inputs it will sample
  task automatic model_step();
    if (!m_gap) begin
      if (m_cyc == STEP_CYCLES - 1) begin
        m_cyc = 0;
        if (m_step == 7) begin
          m_step = 0;
          if (m_per == PERIODS_PER_WIN - 1) begin
            m_per = 0;
            m_gap = 1;
          end else begin
            m_per++;
            m_lev = int'(level_i);
            m_dir = dir_i;
          end
        end else m_step++;
      end else m_cyc++;
    end else begin
      if (m_wcnt == WIN_CYCLES - 1) begin
        m_wcnt = 0;
        m_gap  = 0;
        m_lev  = int'(level_i);
        m_dir  = dir_i;
      end else m_wcnt++;
    end
  endtask

  task automatic drive(int seg);
    case (seg)
      0: begin level_i = 4'd3;  dir_i = 1'b0; brake_i = 1'b0; end
      1: begin level_i = 4'd5;  dir_i = 1'b1; brake_i = 1'b0; end
      2: begin level_i = 4'd8;  dir_i = 1'b1; brake_i = 1'b0; end
      3: begin level_i = 4'd15; dir_i = 1'b0; brake_i = 1'b0; end
      4: begin level_i = 4'd0;  dir_i = 1'b1; brake_i = 1'b0; end
      5: begin  // frequent mid-period changes
        if ($urandom_range(0, 9) == 0) level_i = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 19) == 0) dir_i = ~dir_i;
        brake_i = 1'b0;
      end
      default: begin  // random with brake bursts
        if ($urandom_range(0, 29) == 0) level_i = 4'($urandom_range(0, 9));
        if ($urandom_range(0, 39) == 0) dir_i = ~dir_i;
        if ($urandom_range(0, 24) == 0) brake_i = ~brake_i;
      end
    endcase
  endtask

  initial begin
    int meas_cnt;
    void'($urandom(32'h1d5e_ed01));
    rst_ni  = 1'b0;
    level_i = 4'd8;
    dir_i   = 1'b0;
    brake_i = 1'b0;
    model_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check("R10", 5'b00000);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(0);
    model_step();
    meas_cnt = 0;
    for (int i = 0; i < SEG * NSEG; i++) begin
      @(negedge clk_i);
      check(tag(), expected());
      if (i < SEG && meas_o) meas_cnt++;
      drive(i / SEG);
      model_step();
    end
    // R8: one strobe per gap; SEG cycles from reset cover 5 full gap cycles
    checks++;
    if (meas_cnt != SEG / (8 * STEP_CYCLES * PERIODS_PER_WIN + WIN_CYCLES)) begin
      errors++;
      $display("FAIL R8 strobe count actual=%0d expected=%0d", meas_cnt,
               SEG / (8 * STEP_CYCLES * PERIODS_PER_WIN + WIN_CYCLES));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule